// File: doc/BRIEF.md
# SPI Flash Chip-Select and Clock Sequencer

This block generates the serial clock and the chip-select lines for a serial-flash master. The serial clock is derived from the reference clock by a 4-bit divider. Clock polarity and phase are programmable. The chip-select output carries either a raw code for an external decoder or an internal active-low one-hot pattern. Around every transaction the block enforces four guard intervals, each programmed in reference clocks: the select-to-first-edge lead, the last-edge-to-release lag, the minimum deselected gap, and the gap before addressing a different device.

A transaction is opened with a start strobe. When the lead interval has elapsed, the sequencer raises a ready flag. Each byte request then produces eight serial-clock periods, and a strobe marks every sampling edge. An end request closes the transaction through the lag and gap intervals. Configuration is captured only while the global enable is low. The enable also acts as an abort.

Top module: `spi_cs_sequencer`

## Requirements
- R1: With divider value N, each serial-clock level is held N+1 reference clocks, so one byte lasts 16*(N+1) clocks, with 8*(N+1) of them away from the idle level (N=0 gives ratio 2, N=15 gives ratio 32).
- R2: The serial clock sits at the configured polarity level whenever no byte is being shifted, including at reset.
- R3: Exactly eight sample strobes occur per byte. With phase 0 each one coincides with a leading edge (clock away from idle). With phase 1 each one coincides with a trailing edge (clock back at idle).
- R4: With the decoder enabled, the select lines carry the 4-bit select field unchanged while a device is selected. They read all ones when nothing is selected.
- R5: With the decoder disabled, select k drives only line k low while selected (select 0 gives 1110, select 3 gives 0111).
- R6: From the first cycle the select lines are asserted to the ready flag, exactly lead + 2*(N+1) clocks pass.
- R7: After an end request is accepted, the select lines stay asserted for exactly lag + 2*(N+1) clocks, with the serial clock at its idle level throughout.
- R8: After release, idle stays 0 for exactly gap + 2*(N+1) clocks. Start and byte requests seen during that time are ignored.
- R9: A start whose select value equals that of the previous transaction (or the first transaction after reset) asserts the lines in the next cycle. A start with a different select value holds them released for switch + 2*(N+1) clocks first.
- R10: Idle reads 1 only when no transaction and no guard interval is in progress.
- R11: Configuration is sampled only while enable is low and is frozen while it is high. Enable low returns the outputs to idle (lines released, clock at idle level, idle = 1) after the next clock edge.
- R12: When an end request and a byte request arrive together while ready, the end request wins and no byte is shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable; low = configure / abort |
| cfg_div | input | 4 | Divider N, ratio 2*(N+1) |
| cfg_cpol | input | 1 | Serial-clock idle level |
| cfg_cpha | input | 1 | Sampling edge select |
| cfg_sel | input | 4 | Select value |
| cfg_dec_en | input | 1 | 1 = raw code out, 0 = one-hot active low |
| cfg_t_lead | input | 8 | Extra select-to-first-edge clocks |
| cfg_t_lag | input | 8 | Extra last-edge-to-release clocks |
| cfg_t_gap | input | 8 | Extra minimum deselected clocks |
| cfg_t_switch | input | 8 | Extra clocks before a new device |
| xfer_start | input | 1 | Open a transaction (taken only when idle) |
| byte_req | input | 1 | Shift one byte (taken only when ready) |
| xfer_end | input | 1 | Close the transaction (taken only when ready) |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Chip-select lines |
| sample_stb | output | 1 | High in the cycle of a sampling edge |
| shift_rdy | output | 1 | Selected and waiting for a byte or end request |
| idle | output | 1 | No transaction or guard interval active |

## Verification
Every result has a due cycle. The select lines assert in the first cycle after the start edge, or switch + 2*(N+1) cycles later. The ready flag follows lead + 2*(N+1) cycles after assertion, and a byte occupies 16*(N+1) cycles after its request edge. Release comes lag + 2*(N+1) cycles after the end edge, idle returns gap + 2*(N+1) cycles after release, and the effects of enable appear one edge after it is sampled. The bench drives just after a rising edge and samples on falling edges, counting samples between these events. A queue-based scoreboard holds the lead and byte durations pushed by the driver, and each transaction and divider setting checks its own intervals.

// File: rtl/spi_cs_seq_pkg.sv
package spi_cs_seq_pkg;
    localparam int DIV_W  = 4;
    localparam int DLY_W  = 8;
    localparam int CS_W   = 4;
    localparam int EDGES  = 16;
    localparam int EDGE_W = $clog2(EDGES);
    localparam int CNT_W  = $clog2((1 << DLY_W) + (1 << (DIV_W + 1)));

    typedef enum logic [2:0] {
        ST_IDLE, ST_SWITCH, ST_LEAD, ST_HOLD, ST_SHIFT, ST_LAG, ST_GUARD
    } seq_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cpol;
        logic             cpha;
        logic [CS_W-1:0]  sel;
        logic             dec_en;
        logic [DLY_W-1:0] t_lead;
        logic [DLY_W-1:0] t_lag;
        logic [DLY_W-1:0] t_gap;
        logic [DLY_W-1:0] t_switch;
    } seq_cfg_t;

    // Counter load for "extra + one serial period" cycles: t + 2*(div+1) - 1
    function automatic logic [CNT_W-1:0] guard_load(input logic [DLY_W-1:0] t,
                                                    input logic [DIV_W-1:0] div);
        return CNT_W'(t) + (CNT_W'(div) << 1) + CNT_W'(1);
    endfunction

    function automatic logic [CS_W-1:0] select_lines(input logic [CS_W-1:0] sel,
                                                     input logic dec_en);
        logic [CS_W-1:0] lines;
        if (dec_en) begin
            lines = sel;
        end else begin
            lines = '1;
            for (int i = 0; i < CS_W; i++) begin
                if (sel == CS_W'(i)) lines[i] = 1'b0;
            end
        end
        return lines;
    endfunction
endpackage

// File: rtl/spi_cs_cfg_latch.sv
module spi_cs_cfg_latch
    import spi_cs_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  seq_cfg_t cfg_in,
    output seq_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)      cfg_q <= '0;
        else if (!en) cfg_q <= cfg_in;
    end

    // R11: configuration frozen while enabled
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(cfg_q));
endmodule

// File: rtl/spi_cs_sclk_gen.sv
module spi_cs_sclk_gen
    import spi_cs_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             launch,
    input  logic [DIV_W-1:0] div,
    input  logic             cpol,
    input  logic             cpha,
    output logic             sclk,
    output logic             sample_stb,
    output logic             busy,
    output logic             last_edge
);
    logic [DIV_W-1:0]  half_cnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic              sclk_q;
    logic              tick;

    assign tick      = busy && (half_cnt == '0);
    assign last_edge = tick && (edge_cnt == EDGE_W'(EDGES - 1));
    assign sclk      = busy ? sclk_q : cpol;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy       <= 1'b0;
            half_cnt   <= '0;
            edge_cnt   <= '0;
            sclk_q     <= 1'b0;
            sample_stb <= 1'b0;
        end else begin
            sample_stb <= 1'b0;
            if (launch) begin
                busy     <= 1'b1;
                half_cnt <= div;
                edge_cnt <= '0;
                sclk_q   <= cpol;
            end else if (busy) begin
                if (tick) begin
                    sclk_q     <= ~sclk_q;
                    half_cnt   <= div;
                    edge_cnt   <= edge_cnt + 1'b1;
                    sample_stb <= (edge_cnt[0] == cpha);
                    if (last_edge) busy <= 1'b0;
                end else begin
                    half_cnt <= half_cnt - 1'b1;
                end
            end
        end
    end

    // R1: level holds until the half-period count expires
    a_r1_hold_level: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick && !abort) |=> $stable(sclk));
endmodule

// File: rtl/spi_cs_seq_fsm.sv
module spi_cs_seq_fsm
    import spi_cs_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic [CS_W-1:0]  sel,
    input  logic [DLY_W-1:0] t_lead,
    input  logic [DLY_W-1:0] t_lag,
    input  logic [DLY_W-1:0] t_gap,
    input  logic [DLY_W-1:0] t_switch,
    input  logic             start,
    input  logic             byte_req,
    input  logic             xfer_end,
    input  logic             byte_done,
    output logic             launch,
    output logic             cs_act,
    output logic             hold,
    output logic             idle
);
    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CS_W-1:0]  last_sel;
    logic             has_prev;
    logic             cnt_zero;
    logic             need_switch;

    assign cnt_zero    = (cnt == '0);
    assign need_switch = has_prev && (sel != last_sel);
    assign launch      = en && (state == ST_HOLD) && byte_req && !xfer_end;
    assign cs_act      = (state == ST_LEAD) || (state == ST_HOLD) ||
                         (state == ST_SHIFT) || (state == ST_LAG);
    assign hold        = (state == ST_HOLD);
    assign idle        = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            last_sel <= '0;
            has_prev <= 1'b0;
        end else if (!en) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    last_sel <= sel;
                    has_prev <= 1'b1;
                    if (need_switch) begin
                        state <= ST_SWITCH;
                        cnt   <= guard_load(t_switch, div);
                    end else begin
                        state <= ST_LEAD;
                        cnt   <= guard_load(t_lead, div);
                    end
                end
                ST_SWITCH: if (cnt_zero) begin
                    state <= ST_LEAD;
                    cnt   <= guard_load(t_lead, div);
                end else cnt <= cnt - 1'b1;
                ST_LEAD: if (cnt_zero) state <= ST_HOLD;
                         else cnt <= cnt - 1'b1;
                ST_HOLD: if (xfer_end) begin
                    state <= ST_LAG;
                    cnt   <= guard_load(t_lag, div);
                end else if (byte_req) state <= ST_SHIFT;
                ST_SHIFT: if (byte_done) state <= ST_HOLD;
                ST_LAG: if (cnt_zero) begin
                    state <= ST_GUARD;
                    cnt   <= guard_load(t_gap, div);
                end else cnt <= cnt - 1'b1;
                ST_GUARD: if (cnt_zero) state <= ST_IDLE;
                          else cnt <= cnt - 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R12: end request beats a simultaneous byte request
    a_r12_end_wins: assert property (@(posedge clk) disable iff (rst)
        (hold && en && xfer_end) |=> (state == ST_LAG));
    // R8: start during the deselect guard does not select a device
    a_r8_guard_ignores_start: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_GUARD) && en && start) |=> !cs_act);
    // R7: the lag interval is entered only from the ready state
    a_r7_lag_after_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_LAG) |-> ($past(state) == ST_HOLD));
endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
    import spi_cs_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic [CS_W-1:0]  cfg_sel,
    input  logic             cfg_dec_en,
    input  logic [DLY_W-1:0] cfg_t_lead,
    input  logic [DLY_W-1:0] cfg_t_lag,
    input  logic [DLY_W-1:0] cfg_t_gap,
    input  logic [DLY_W-1:0] cfg_t_switch,
    input  logic             xfer_start,
    input  logic             byte_req,
    input  logic             xfer_end,
    output logic             sclk,
    output logic [CS_W-1:0]  cs_n,
    output logic             sample_stb,
    output logic             shift_rdy,
    output logic             idle
);
    seq_cfg_t cfg_in;
    seq_cfg_t cfg_q;
    logic     launch;
    logic     cs_act;
    logic     clk_busy;
    logic     last_edge;

    always_comb begin
        cfg_in.div      = cfg_div;
        cfg_in.cpol     = cfg_cpol;
        cfg_in.cpha     = cfg_cpha;
        cfg_in.sel      = cfg_sel;
        cfg_in.dec_en   = cfg_dec_en;
        cfg_in.t_lead   = cfg_t_lead;
        cfg_in.t_lag    = cfg_t_lag;
        cfg_in.t_gap    = cfg_t_gap;
        cfg_in.t_switch = cfg_t_switch;
    end

    spi_cs_cfg_latch u_cfg (
        .clk(clk), .rst(rst), .en(en), .cfg_in(cfg_in), .cfg_q(cfg_q)
    );

    spi_cs_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .en(en),
        .div(cfg_q.div), .sel(cfg_q.sel),
        .t_lead(cfg_q.t_lead), .t_lag(cfg_q.t_lag),
        .t_gap(cfg_q.t_gap), .t_switch(cfg_q.t_switch),
        .start(xfer_start), .byte_req(byte_req), .xfer_end(xfer_end),
        .byte_done(last_edge), .launch(launch), .cs_act(cs_act),
        .hold(shift_rdy), .idle(idle)
    );

    spi_cs_sclk_gen u_sclk (
        .clk(clk), .rst(rst), .abort(!en), .launch(launch),
        .div(cfg_q.div), .cpol(cfg_q.cpol), .cpha(cfg_q.cpha),
        .sclk(sclk), .sample_stb(sample_stb), .busy(clk_busy),
        .last_edge(last_edge)
    );

    assign cs_n = cs_act ? select_lines(cfg_q.sel, cfg_q.dec_en) : '1;

    // R2: no clock activity while no device is selected
    a_r2_sclk_idle_deselected: assert property (@(posedge clk) disable iff (rst)
        !cs_act |-> (sclk == cfg_q.cpol));
    // R5: internal decode never drives more than one line low
    a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
        (cs_act && !cfg_q.dec_en) |-> $onehot0(~cs_n));
    // R10: idle implies released lines and a stopped clock
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        idle |-> ((cs_n == '1) && !clk_busy));
    // R6: shifting only happens with a device selected
    a_r6_shift_selected: assert property (@(posedge clk) disable iff (rst)
        clk_busy |-> cs_act);
endmodule

// File: tb/tb_spi_cs_sequencer.sv
module tb_spi_cs_sequencer;
    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic [3:0] cfg_div;
    logic       cfg_cpol, cfg_cpha, cfg_dec_en;
    logic [3:0] cfg_sel;
    logic [7:0] cfg_t_lead, cfg_t_lag, cfg_t_gap, cfg_t_switch;
    logic       xfer_start, byte_req, xfer_end;
    logic       sclk, sample_stb, shift_rdy, idle;
    logic [3:0] cs_n;
    logic       cs_active;

    int checks = 0;
    int errors = 0;
    int lead_q[$];
    int len_q[$];
    int hi_q[$];

    int         cur_div;
    logic       cur_cpol, cur_cpha;
    logic [3:0] cur_lines;

    always #4 clk = ~clk;

    assign cs_active = (cs_n != 4'hF);

    spi_cs_sequencer dut (
        .clk(clk), .rst(rst), .en(en),
        .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_sel(cfg_sel), .cfg_dec_en(cfg_dec_en),
        .cfg_t_lead(cfg_t_lead), .cfg_t_lag(cfg_t_lag),
        .cfg_t_gap(cfg_t_gap), .cfg_t_switch(cfg_t_switch),
        .xfer_start(xfer_start), .byte_req(byte_req), .xfer_end(xfer_end),
        .sclk(sclk), .cs_n(cs_n), .sample_stb(sample_stb),
        .shift_rdy(shift_rdy), .idle(idle)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic logic [3:0] exp_lines(input logic [3:0] s, input logic d);
        return d ? s : (4'hF & ~(4'h1 << s));
    endfunction

    task automatic configure(input int dv, input logic pol, input logic pha,
                             input logic [3:0] s, input logic d,
                             input int tl, input int tg, input int tp, input int ts);
        @(posedge clk); #1;
        en = 1'b0;
        cfg_div = 4'(dv); cfg_cpol = pol; cfg_cpha = pha; cfg_sel = s; cfg_dec_en = d;
        cfg_t_lead = 8'(tl); cfg_t_lag = 8'(tg); cfg_t_gap = 8'(tp); cfg_t_switch = 8'(ts);
        @(posedge clk); #1;
        en = 1'b1;
        cur_div = dv; cur_cpol = pol; cur_cpha = pha; cur_lines = exp_lines(s, d);
    endtask

    task automatic wait_rdy();
        do @(negedge clk); while (!shift_rdy);
    endtask

    task automatic start_txn(input int pre, input int lead, input string line_req);
        int n;
        n = 0;
        lead_q.push_back(lead);
        @(posedge clk); #1 xfer_start = 1'b1;
        @(posedge clk); #1 xfer_start = 1'b0;
        @(negedge clk);
        check("R10", idle, 0, "idle after start");
        while (!cs_active) begin
            n++;
            @(negedge clk);
        end
        check("R9", n, pre, "cycles before select");
        check(line_req, cs_n, cur_lines, "select lines");
    endtask

    task automatic do_byte();
        wait_rdy();
        len_q.push_back(16 * (cur_div + 1));
        hi_q.push_back(8 * (cur_div + 1));
        @(posedge clk); #1 byte_req = 1'b1;
        @(posedge clk); #1 byte_req = 1'b0;
    endtask

    task automatic end_txn(input int lag, input int gap, input bit both, input bit poke);
        int n, bad, g;
        n = 0; bad = 0; g = 0;
        wait_rdy();
        @(posedge clk); #1 xfer_end = 1'b1; byte_req = both;
        @(posedge clk); #1 xfer_end = 1'b0; byte_req = 1'b0;
        forever begin
            @(negedge clk);
            if (!cs_active) break;
            n++;
            if (sclk != cur_cpol) bad++;
        end
        check("R7", n, lag, "lag length");
        check("R7", bad, 0, "clock off idle during lag");
        if (both) check("R12", bad + n, lag, "end beats byte request");
        while (!idle) begin
            g++;
            if (cs_active) bad++;
            if (poke && g == 2) begin
                @(posedge clk); #1 xfer_start = 1'b1; byte_req = 1'b1;
            end else if (poke && g == 3) begin
                @(posedge clk); #1 xfer_start = 1'b0; byte_req = 1'b0;
            end
            @(negedge clk);
        end
        check("R8", g, gap, "deselect gap");
        if (poke) begin
            bad = 0;
            repeat (4) begin
                @(negedge clk);
                if (!idle || cs_active || sclk != cur_cpol) bad++;
            end
            check("R8", bad, 0, "requests during gap ignored");
        end
    endtask

    // Scoreboard: lead interval per transaction
    initial begin : lead_mon
        bit counting;
        bit prev_act;
        int n;
        counting = 0; prev_act = 0; n = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                counting = 0;
                prev_act = 0;
            end else begin
                if (cs_active && !prev_act && !shift_rdy) begin
                    counting = 1;
                    n = 0;
                end
                if (counting) begin
                    if (shift_rdy) begin
                        counting = 0;
                        if (lead_q.size() == 0) check("R6", n, -1, "unexpected lead");
                        else check("R6", n, lead_q.pop_front(), "lead length");
                    end else if (cs_active) n++;
                    else counting = 0;
                end
                prev_act = cs_active;
            end
        end
    end

    // Scoreboard: byte timing and sample strobes
    initial begin : byte_mon
        int len, hi, stb, phase_bad;
        forever begin
            @(negedge clk);
            if (!rst && en && shift_rdy && byte_req && !xfer_end) begin
                len = 0; hi = 0; stb = 0; phase_bad = 0;
                do begin
                    @(negedge clk);
                    if (sample_stb) begin
                        stb++;
                        if ((sclk != cur_cpol) != !cur_cpha) phase_bad++;
                    end
                    if (!shift_rdy) begin
                        len++;
                        if (sclk != cur_cpol) hi++;
                    end
                end while (!shift_rdy && en);
                if (len_q.size() == 0) check("R1", len, -1, "unexpected byte");
                else begin
                    check("R1", len, len_q.pop_front(), "byte length");
                    check("R1", hi, hi_q.pop_front(), "clock active-level cycles");
                end
                check("R3", stb, 8, "sample strobes per byte");
                check("R3", phase_bad, 0, "strobes on wrong edge");
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin : main
        rst = 1'b1; en = 1'b0;
        cfg_div = '0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_sel = '0; cfg_dec_en = 1'b0;
        cfg_t_lead = '0; cfg_t_lag = '0; cfg_t_gap = '0; cfg_t_switch = '0;
        xfer_start = 1'b0; byte_req = 1'b0; xfer_end = 1'b0;
        cur_div = 0; cur_cpol = 1'b0; cur_cpha = 1'b0; cur_lines = 4'hF;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R10", idle, 1, "idle at reset");
        check("R4", cs_n, 4'hF, "lines released at reset");
        check("R2", sclk, 0, "clock at reset");
        check("R6", shift_rdy, 0, "not ready at reset");
        check("R3", sample_stb, 0, "no strobe at reset");

        // N=1, mode 0, one-hot select 2
        configure(1, 1'b0, 1'b0, 4'd2, 1'b0, 3, 2, 5, 7);
        start_txn(0, 3 + 4, "R5");
        do_byte();
        do_byte();
        end_txn(2 + 4, 5 + 4, 1'b0, 1'b0);
        start_txn(0, 7, "R5");
        do_byte();
        end_txn(6, 9, 1'b0, 1'b1);

        // N=3, mode 3, raw code 5 (device switch)
        configure(3, 1'b1, 1'b1, 4'd5, 1'b1, 0, 0, 0, 4);
        start_txn(4 + 8, 0 + 8, "R4");
        do_byte();
        end_txn(8, 8, 1'b0, 1'b0);

        // N=15 (ratio 32), mode 1, one-hot select 3, simultaneous end and byte
        configure(15, 1'b0, 1'b1, 4'd3, 1'b0, 255, 255, 10, 1);
        start_txn(1 + 32, 255 + 32, "R5");
        do_byte();
        end_txn(255 + 32, 10 + 32, 1'b1, 1'b0);

        // N=0 (ratio 2), mode 2, one-hot select 0, then abort by enable
        configure(0, 1'b1, 1'b0, 4'd0, 1'b0, 1, 1, 1, 2);
        start_txn(2 + 2, 1 + 2, "R5");
        do_byte();
        wait_rdy();
        @(posedge clk); #1 en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11", cs_n, 4'hF, "lines released on disable");
        check("R11", idle, 1, "idle on disable");
        check("R11", sclk, cur_cpol, "clock idle on disable");
        cfg_cpol = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11", sclk, 0, "polarity sampled while disabled");
        @(posedge clk); #1 en = 1'b1;
        @(posedge clk); #1 cfg_cpol = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R11", sclk, 0, "polarity frozen while enabled");
        check("R2", idle, 1, "still idle after re-enable");

        summary();
        $finish;
    end
endmodule